// File: doc/BRIEF.md
# I2C GPIO Expander Target

This block is an I2C target that drives an 8-bit general-purpose I/O port through four byte-wide registers. The registers hold the output value, the polarity inversion mask, the direction mask, and the input value. It runs on a fast system clock and oversamples the bus. SCL and SDA pass through a two-flop synchronizer, and START and STOP are detected from edges on the synchronized lines. The target only pulls SDA low, so the line is open-drain; it never holds SCL.

A controller opens a write transaction with the target address. The first byte after the address selects one register through its two low bits. Any further bytes in that transaction are written to the selected register. A read transaction carries no command byte. It streams the register that was selected last, and that selection holds across transactions until a new command byte replaces it. Each pin is driven from the output register when its direction bit is 0 and released when the bit is 1. The input value is the synchronized pin state with the polarity mask applied.

Top module: `gpx_expander`

## Requirements
- R1: The target acknowledges only the 7-bit address formed by binary 0111 in the upper four bits and `strap_i[2:0]` in the lower three. On any other address it leaves SDA released for the rest of that transaction, including later bytes, until the next START.
- R2: The bit after the address selects the transfer. A 1 makes the target send data and a 0 makes it receive. A repeated START may switch from a write to a read.
- R3: In a write transaction the first byte after the address is the command byte and is acknowledged. Its two low bits select the register: 0 input, 1 output, 2 polarity mask, 3 direction mask.
- R4: The register selection persists across transactions and reads never change it. Every read byte comes from the last selected register. After reset the selection is the input register.
- R5: After reset `port_o` is 0xFF, `port_oe_o` is 0x00 (all direction bits 1), and the polarity mask is 0x00.
- R6: Every data byte after the command byte is acknowledged and written to the selected register. Consecutive bytes go to the same register; the last one wins.
- R7: A data byte written while the input register is selected is acknowledged but changes no register.
- R8: `port_oe_o[i]` is 1 exactly when direction bit i is 0. `port_o` always carries the output register.
- R9: Reading the input register returns the synchronized `port_i` XOR the polarity mask.
- R10: Read data leaves MSB first, and SDA is released in the ninth clock. After a controller ACK the target sends the next byte. After a NACK it keeps SDA released until the next START.
- R11: The target changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 3 | Low three address bits |
| port_i | input | 8 | Pin levels (asynchronous) |
| port_o | output | 8 | Output register value |
| port_oe_o | output | 8 | Per-pin drive enable, 1 drives the pin |

## Verification
Register traffic uses asymmetric values such as 0x3C, 0x5A and 0xA5, so a bit-order or bit-position fault changes the readback. Addressing is tried with the matching address, with a wrong strap bit, and with a wrong fixed bit; the no-acknowledge on the data byte that follows a mismatch separates "stays idle" from "misses one ACK". Pointer handling is tried with command-only writes followed by separate reads, with bursts of ACKed reads, and with a repeated START. These tell a pointer that persists apart from one that resets or auto-increments. A dummy byte clocked after a NACK shows that the target is silent. Input reads with two polarity masks and two pin patterns separate the XOR path from a plain pass-through.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  parameter int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    REG_IN  = 2'd0,
    REG_OUT = 2'd1,
    REG_POL = 2'd2,
    REG_CFG = 2'd3
  } reg_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_TACK,
    ST_RD,
    ST_RACK,
    ST_RLOAD
  } bus_st_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int unsigned   W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s0_q, s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q <= RST_VAL;
      s1_q <= RST_VAL;
    end else begin
      s0_q <= d_i;
      s1_q <= s0_q;
    end
  end

  assign q_o = s1_q;
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] port_o,
  output logic [W-1:0] port_oe_o
);
  logic [W-1:0] out_q, pol_q, cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '1;
      pol_q <= '0;
      cfg_q <= '1;
    end else if (we_i) begin
      unique case (sel_i)
        REG_OUT: out_q <= wdata_i;
        REG_POL: pol_q <= wdata_i;
        REG_CFG: cfg_q <= wdata_i;
        default: ;  // input register is read-only
      endcase
    end
  end

  always_comb begin
    unique case (sel_i)
      REG_IN:  rdata_o = pins_i ^ pol_q;
      REG_OUT: rdata_o = out_q;
      REG_POL: rdata_o = pol_q;
      default: rdata_o = cfg_q;
    endcase
  end

  assign port_o    = out_q;
  assign port_oe_o = ~cfg_q;
endmodule

// File: rtl/gpx_bus.sv
module gpx_bus
  import gpx_pkg::*;
#(
  parameter int unsigned                 STRAP_W = 3,
  parameter logic [BYTE_W-2-STRAP_W:0]   ADDR_HI = 4'b0111
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  rdata_i,
  output logic               sda_oe_o,
  output logic               we_o,
  output reg_sel_e           sel_o,
  output logic [BYTE_W-1:0]  wdata_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  bus_st_e          st_q, nxt_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q;
  reg_sel_e         ptr_q;
  logic             oe_q, scl_q, sda_q;

  logic scl_rise, scl_fall, start_det, stop_det, byte_end, addr_hit;

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  assign byte_end  = scl_fall && (cnt_q == LAST);
  assign addr_hit  = (sh_q[BYTE_W-1:1] == {ADDR_HI, strap_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      nxt_q <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      tx_q  <= '0;
      ptr_q <= REG_IN;
      oe_q  <= 1'b0;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_det) begin
        st_q  <= ST_ADDR;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else if (stop_det) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + CNT_W'(1);
            end else if (byte_end) begin
              cnt_q <= '0;
              if (st_q == ST_ADDR) begin
                if (addr_hit) begin
                  oe_q  <= 1'b1;
                  st_q  <= ST_TACK;
                  nxt_q <= sh_q[0] ? ST_RLOAD : ST_CMD;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else begin
                if (st_q == ST_CMD) ptr_q <= reg_sel_e'(sh_q[1:0]);
                oe_q  <= 1'b1;
                st_q  <= ST_TACK;
                nxt_q <= ST_WDATA;
              end
            end
          end
          ST_TACK: begin
            if (scl_fall) begin
              if (nxt_q == ST_RLOAD) begin
                oe_q  <= ~rdata_i[BYTE_W-1];
                tx_q  <= {rdata_i[BYTE_W-2:0], 1'b0};
                cnt_q <= '0;
                st_q  <= ST_RD;
              end else begin
                oe_q <= 1'b0;
                st_q <= nxt_q;
              end
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + CNT_W'(1);
            end else if (scl_fall) begin
              if (cnt_q == LAST) begin
                oe_q <= 1'b0;
                st_q <= ST_RACK;
              end else begin
                oe_q <= ~tx_q[BYTE_W-1];
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RACK: if (scl_rise) st_q <= sda_i ? ST_IDLE : ST_RLOAD;
          ST_RLOAD: begin
            if (scl_fall) begin
              oe_q  <= ~rdata_i[BYTE_W-1];
              tx_q  <= {rdata_i[BYTE_W-2:0], 1'b0};
              cnt_q <= '0;
              st_q  <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign we_o     = (st_q == ST_WDATA) && byte_end && !start_det && !stop_det;
  assign wdata_o  = sh_q;
  assign sel_o    = ptr_q;
  assign sda_oe_o = oe_q;
endmodule

// File: rtl/gpx_expander.sv
module gpx_expander
  import gpx_pkg::*;
#(
  parameter int unsigned STRAP_W = 3,
  parameter logic [BYTE_W-2-STRAP_W:0] ADDR_HI = 4'b0111
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  port_i,
  output logic [BYTE_W-1:0]  port_o,
  output logic [BYTE_W-1:0]  port_oe_o
);
  logic              scl_s, sda_s, bus_we;
  logic [BYTE_W-1:0] pins_s, rdata, wdata;
  reg_sel_e          bus_sel;

  gpx_sync #(.W(2), .RST_VAL(2'b11)) u_sync_bus (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
  );

  gpx_sync #(.W(BYTE_W), .RST_VAL('0)) u_sync_pins (
    .clk_i, .rst_ni, .d_i(port_i), .q_o(pins_s)
  );

  gpx_bus #(.STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI)) u_bus (
    .clk_i, .rst_ni,
    .scl_i(scl_s), .sda_i(sda_s), .strap_i,
    .rdata_i(rdata), .sda_oe_o,
    .we_o(bus_we), .sel_o(bus_sel), .wdata_o(wdata)
  );

  gpx_regs #(.W(BYTE_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(bus_we), .sel_i(bus_sel), .wdata_i(wdata), .pins_i(pins_s),
    .rdata_o(rdata), .port_o, .port_oe_o
  );
endmodule

// File: rtl/gpx_expander_chk.sv
module gpx_expander_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         scl_s,
  input logic         sda_oe,
  input logic         we,
  input logic [1:0]   sel,
  input logic [W-1:0] port_o,
  input logic [W-1:0] port_oe_o
);
  p_sda_scl_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe) |-> !scl_s);

  p_ack_on_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |=> sda_oe);

  p_out_only_by_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(port_o) |-> $past(we && sel == 2'd1));

  p_dir_only_by_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(port_oe_o) |-> $past(we && sel == 2'd3));

  p_input_write_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && sel == 2'd0) |=> ($stable(port_o) && $stable(port_oe_o)));
endmodule

bind gpx_expander gpx_expander_chk #(.W(gpx_pkg::BYTE_W)) u_chk (
  .clk_i, .rst_ni, .scl_s(scl_s), .sda_oe(sda_oe_o), .we(bus_we),
  .sel(bus_sel), .port_o, .port_oe_o
);

// File: tb/tb_gpx_expander.sv
module tb_gpx_expander;
  localparam int Q = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] ADR = {4'b0111, STRAP};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [7:0] pins = 8'h00;
  logic sda_oe;
  logic [7:0] port_o, port_oe;
  logic sda_bus;
  int n_chk = 0, n_fail = 0, n_r11 = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  gpx_expander dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .strap_i(STRAP), .port_i(pins),
    .port_o(port_o), .port_oe_o(port_oe)
  );

  // R11 monitor: target drive may only move while SCL is low
  logic oe_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && (sda_oe !== oe_d)) n_r11++;
    oe_d <= sda_oe;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = sda_bus; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic rd_byte(input logic ack_m, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(~ack_m);
  endtask

  task automatic reg_write(input logic [7:0] cmd, input logic [7:0] data, input string req);
    logic a0, a1, a2;
    i2c_start(); wr_byte({ADR, 1'b0}, a0); wr_byte(cmd, a1); wr_byte(data, a2); i2c_stop();
    chk(req, {5'b0, a0, a1, a2}, 8'h07);
  endtask

  task automatic set_ptr(input logic [7:0] cmd);
    logic a0, a1;
    i2c_start(); wr_byte({ADR, 1'b0}, a0); wr_byte(cmd, a1); i2c_stop();
    chk("R3 command ack", {6'b0, a0, a1}, 8'h03);
  endtask

  task automatic reg_read(input logic [7:0] exp, input string req);
    logic a; logic [7:0] d;
    i2c_start(); wr_byte({ADR, 1'b1}, a); rd_byte(1'b0, d); i2c_stop();
    chk("R2 read address ack", {7'b0, a}, 8'h01);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    chk("R5 port_o reset", port_o, 8'hFF);
    chk("R5 port_oe reset", port_oe, 8'h00);
  endtask

  task automatic t_default_ptr();
    pins = 8'hA5; wq();
    reg_read(8'hA5, "R4 reset pointer is input, R9 no inversion");
    set_ptr(8'h02);
    reg_read(8'h00, "R5 polarity reset");
  endtask

  task automatic t_addr();
    logic a0, a1;
    i2c_start(); wr_byte({7'h3C, 1'b0}, a0); wr_byte(8'h01, a1); i2c_stop();
    chk("R1 strap mismatch nack", {6'b0, a0, a1}, 8'h00);
    i2c_start(); wr_byte({7'h5D, 1'b0}, a0); wr_byte(8'h01, a1); wr_byte(8'h00, a1); i2c_stop();
    chk("R1 fixed bits mismatch nack", {6'b0, a0, a1}, 8'h00);
    chk("R1 mismatch writes nothing", port_o, 8'hFF);
    reg_read(8'h00, "R1 pointer kept after mismatch");
  endtask

  task automatic t_write_out();
    logic a0, a1, a2, a3;
    reg_write(8'h01, 8'h3C, "R6 write output acks");
    chk("R6 output value", port_o, 8'h3C);
    i2c_start(); wr_byte({ADR, 1'b0}, a0); wr_byte(8'h01, a1);
    wr_byte(8'h11, a2); wr_byte(8'h22, a3); i2c_stop();
    chk("R6 burst acks", {4'b0, a0, a1, a2, a3}, 8'h0F);
    chk("R6 last byte wins", port_o, 8'h22);
    reg_read(8'h22, "R3 output readback");
  endtask

  task automatic t_cfg();
    reg_write(8'h03, 8'h0F, "R3 direction write acks");
    chk("R8 drive enables", port_oe, 8'hF0);
    chk("R8 output value kept", port_o, 8'h22);
    reg_read(8'h0F, "R3 direction readback");
  endtask

  task automatic t_pol();
    reg_write(8'h02, 8'hFF, "R3 polarity write acks");
    set_ptr(8'h00);
    pins = 8'hA5; wq();
    reg_read(8'h5A, "R9 inverted input");
    pins = 8'h0F; wq();
    reg_read(8'hF0, "R9 inverted input 2");
    reg_write(8'h02, 8'h3C, "R3 polarity write acks");
    set_ptr(8'h00);
    reg_read(8'h33, "R9 partial inversion");
  endtask

  task automatic t_persist();
    logic a; logic [7:0] d0, d1, d2;
    set_ptr(8'h03);
    reg_read(8'h0F, "R4 first read");
    reg_read(8'h0F, "R4 second read");
    i2c_start(); wr_byte({ADR, 1'b1}, a);
    rd_byte(1'b1, d0); rd_byte(1'b0, d1); rd_byte(1'b0, d2); i2c_stop();
    chk("R10 burst byte 0", d0, 8'h0F);
    chk("R10 burst byte 1 after ack", d1, 8'h0F);
    chk("R10 silent after nack", d2, 8'hFF);
  endtask

  task automatic t_in_ignored();
    reg_write(8'h00, 8'h00, "R7 input write acked");
    chk("R7 port_o unchanged", port_o, 8'h22);
    chk("R7 port_oe unchanged", port_oe, 8'hF0);
    set_ptr(8'h02);
    reg_read(8'h3C, "R7 polarity unchanged");
  endtask

  task automatic t_rep_start();
    logic a0, a1, a2; logic [7:0] d;
    i2c_start(); wr_byte({ADR, 1'b0}, a0); wr_byte(8'h01, a1);
    i2c_start(); wr_byte({ADR, 1'b1}, a2); rd_byte(1'b0, d); i2c_stop();
    chk("R2 repeated start acks", {5'b0, a0, a1, a2}, 8'h07);
    chk("R2 read after repeated start", d, 8'h22);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_default_ptr();
    t_addr();
    t_write_out();
    t_cfg();
    t_pol();
    t_persist();
    t_in_ignored();
    t_rep_start();
    chk("R11 drive changes with SCL high", 8'(n_r11), 8'h00);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule